// File: doc/BRIEF.md
# Drift-Corrected Hardware Timebase Counter

This block keeps a 64-bit nanosecond time count for precision time stamping. Every clock cycle while running it advances by a fixed nominal step of 16 ns. Its rate can be trimmed by a periodic correction: once every programmable number of 16 ns quanta, that tick's step is lengthened or shortened by 0 to 7 ns. Stamping logic elsewhere on the chip samples the live count on `time_ns`.

Software drives the block through simple single-cycle register writes and reads. It can pause and resume the count, preload either 32-bit half while paused, arm and release the drift logic, and load a 32-bit drift word. It reads the time back as two 32-bit words. Reading the low word latches the high word at the same instant, so the pair stays coherent even if a carry into the high word happens between the two reads. Write addresses: 0 command, 1 preload low, 2 preload high, 3 drift reset, 4 drift word. Read addresses: 0 time low, 1 time high (latched), 3 drift reset, 4 drift word; any other address reads zero.

Top module: `timebase_counter`

## Requirements
- R1: After reset `time_ns` is 0, the count is running, the drift reset bit is 0, the drift word is 0 and `rd_data` is 0.
- R2: While running with no correction due, `time_ns` grows by exactly 16 on each clock edge. A change to the run state written at an edge governs the edges after it.
- R3: Writing the value 2 to address 0 pauses the count and writing 4 resumes it. Any other value written there leaves the run state unchanged. While paused `time_ns` holds.
- R4: While paused, a write to address 1 replaces bits [31:0] of the count and a write to address 2 replaces bits [63:32]. The same writes are ignored while running.
- R5: A write to address 4 loads the drift word only when the drift reset bit is 1 before that edge. Otherwise the stored word is unchanged, as a read of address 4 shows.
- R6: Drift word fields: bits [27:0] are the period P in ticks, bits [30:28] are the magnitude M in ns, and bit 31 selects add (1) or subtract (0). With the drift reset bit at 0 and P nonzero, every P-th running tick advances by 16+M or 16-M, and every other tick advances by 16.
- R7: A drift word of zero disables correction. A magnitude of 0 with a period of 0xFFFFFFF gives a plain 16 ns step on every tick.
- R8: Writing address 3 sets the drift reset bit to `wr_data[0]` and restarts the period count. While the bit is 1, no correction is applied.
- R9: While paused, the period count does not advance, so a correction interval interrupted by a pause continues where it stopped.
- R10: `rd_data` updates at the edge after `rd_en`. Reading address 0 returns bits [31:0] and latches bits [63:32]. Reading address 1 returns the latched word. Address 3 reads the drift reset bit in bit 0, and address 4 reads the stored drift word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| time_ns | output | 64 | Live nanosecond count |

## Verification
A write takes effect at the clock edge where it is sampled, and it changes `time_ns` from the following edge on. A pause still lets the tick at its own edge advance, and read data appears one edge after the strobe. The bench drives inputs just after each rising edge and keeps a behavioural model that updates on the same edges. At every falling edge it compares both `time_ns` and `rd_data` with that model, so each result is checked in exactly the cycle it is due. A few directed checks cover pause hold, ignored drift writes and held drift reset by computing the expected values from elapsed cycle counts.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    localparam int TIME_W   = 64;
    localparam int WORD_W   = 32;
    localparam int NWORDS   = TIME_W / WORD_W;
    localparam int ADDR_W   = 3;
    localparam int PERIOD_W = 28;
    localparam int MAG_W    = 3;
    localparam int INC_W    = 8;
    localparam int STEP_NS  = 16;

    // write map
    localparam logic [ADDR_W-1:0] WA_CMD    = 3'd0;
    localparam logic [ADDR_W-1:0] WA_PRE_LO = 3'd1;
    localparam logic [ADDR_W-1:0] WA_PRE_HI = 3'd2;
    localparam logic [ADDR_W-1:0] WA_DRST   = 3'd3;
    localparam logic [ADDR_W-1:0] WA_DCFG   = 3'd4;
    // read map
    localparam logic [ADDR_W-1:0] RA_TLO    = 3'd0;
    localparam logic [ADDR_W-1:0] RA_THI    = 3'd1;
    localparam logic [ADDR_W-1:0] RA_DRST   = 3'd3;
    localparam logic [ADDR_W-1:0] RA_DCFG   = 3'd4;

    localparam logic [WORD_W-1:0] CMD_PAUSE  = 32'd2;
    localparam logic [WORD_W-1:0] CMD_RESUME = 32'd4;

    typedef struct packed {
        logic                add;
        logic [MAG_W-1:0]    mag;
        logic [PERIOD_W-1:0] period;
    } drift_cfg_t;

    // step applied on one tick, corrected or not
    function automatic logic [INC_W-1:0] tick_inc(input drift_cfg_t c, input logic corr);
        logic [INC_W-1:0] base;
        logic [INC_W-1:0] m;
        base = INC_W'(STEP_NS);
        m    = INC_W'(c.mag);
        if (!corr)      return base;
        else if (c.add) return base + m;
        else            return base - m;
    endfunction
endpackage

// File: rtl/tbc_regs.sv
module tbc_regs
    import tbc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W,
    parameter int NW = NWORDS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          run_q,
    output logic          drift_rst_q,
    output drift_cfg_t    cfg_q,
    output logic [NW-1:0] pl_we,
    output logic          drift_clr
);
    logic wr_cmd, wr_drst, wr_dcfg;

    assign wr_cmd    = wr_en && (wr_addr == WA_CMD);
    assign wr_drst   = wr_en && (wr_addr == WA_DRST);
    assign wr_dcfg   = wr_en && (wr_addr == WA_DCFG);
    assign drift_clr = wr_drst;

    // one preload strobe per count word, gated by pause
    for (genvar i = 0; i < NW; i++) begin : g_pl
        localparam logic [AW-1:0] WADDR = AW'(int'(WA_PRE_LO) + i);
        assign pl_we[i] = wr_en && !run_q && (wr_addr == WADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q       <= 1'b1;
            drift_rst_q <= 1'b0;
            cfg_q       <= '0;
        end else begin
            if (wr_cmd) begin
                if (wr_data == CMD_PAUSE)       run_q <= 1'b0;
                else if (wr_data == CMD_RESUME) run_q <= 1'b1;
            end
            if (wr_drst)
                drift_rst_q <= wr_data[0];
            if (wr_dcfg && drift_rst_q)
                cfg_q <= drift_cfg_t'(wr_data);
        end
    end
endmodule

// File: rtl/tbc_drift.sv
module tbc_drift
    import tbc_pkg::*;
#(
    parameter int PW = PERIOD_W,
    parameter int IW = INC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          hold,
    input  logic          clr,
    input  drift_cfg_t    cfg,
    output logic [IW-1:0] inc
);
    logic [PW-1:0] pcnt_q;
    logic          active;
    logic          hit;

    assign active = !hold && (cfg.period != '0);
    assign hit    = active && (({1'b0, pcnt_q} + 1'b1) == {1'b0, cfg.period});
    assign inc    = tick_inc(cfg, hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (clr) begin
            pcnt_q <= '0;
        end else if (adv && active) begin
            if (hit) pcnt_q <= '0;
            else     pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tbc_count.sv
module tbc_count
    import tbc_pkg::*;
#(
    parameter int TW = TIME_W,
    parameter int DW = WORD_W,
    parameter int NW = NWORDS,
    parameter int IW = INC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [IW-1:0] inc,
    input  logic [NW-1:0] pl_we,
    input  logic [DW-1:0] pl_data,
    output logic [TW-1:0] cnt_q
);
    logic [TW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (adv)
            cnt_d = cnt_q + TW'(inc);
        for (int i = 0; i < NW; i++) begin
            if (pl_we[i])
                cnt_d[i*DW +: DW] = pl_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tbc_readout.sv
module tbc_readout
    import tbc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W,
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [TW-1:0] cnt,
    input  logic          drift_rst,
    input  drift_cfg_t    cfg,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] snap_q;
    logic [DW-1:0] sel;

    always_comb begin
        case (rd_addr)
            RA_TLO:  sel = cnt[DW-1:0];
            RA_THI:  sel = snap_q;
            RA_DRST: sel = DW'(drift_rst);
            RA_DCFG: sel = DW'(cfg);
            default: sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            snap_q  <= '0;
        end else if (rd_en) begin
            rd_data <= sel;
            if (rd_addr == RA_TLO)
                snap_q <= cnt[TW-1:DW];
        end
    end
endmodule

// File: rtl/timebase_counter.sv
module timebase_counter
    import tbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic [TIME_W-1:0]   time_ns
);
    logic              run_q;
    logic              drift_rst_q;
    drift_cfg_t        cfg_q;
    logic [NWORDS-1:0] pl_we;
    logic              drift_clr;
    logic [INC_W-1:0]  inc;

    tbc_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .run_q(run_q), .drift_rst_q(drift_rst_q), .cfg_q(cfg_q),
        .pl_we(pl_we), .drift_clr(drift_clr)
    );

    tbc_drift u_drift (
        .clk(clk), .rst(rst),
        .adv(run_q), .hold(drift_rst_q), .clr(drift_clr),
        .cfg(cfg_q), .inc(inc)
    );

    tbc_count u_count (
        .clk(clk), .rst(rst),
        .adv(run_q), .inc(inc),
        .pl_we(pl_we), .pl_data(wr_data),
        .cnt_q(time_ns)
    );

    tbc_readout u_read (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .cnt(time_ns), .drift_rst(drift_rst_q), .cfg(cfg_q),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/tbc_checker.sv
module tbc_checker
    import tbc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [WORD_W-1:0]   rd_data,
    input logic [TIME_W-1:0]   time_ns,
    input logic                running,
    input logic                drift_rst,
    input drift_cfg_t          cfg
);
    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        running |=> ((time_ns - $past(time_ns)) >= 64'd9) && ((time_ns - $past(time_ns)) <= 64'd23));

    // R3
    paused_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !(wr_en && (wr_addr == WA_PRE_LO || wr_addr == WA_PRE_HI))) |=> $stable(time_ns));

    // R8
    no_corr_in_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (running && drift_rst) |=> (time_ns == $past(time_ns) + 64'd16));

    // R5
    cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == WA_DCFG && !drift_rst) |=> $stable(cfg));

    // R10
    hi_coherent_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en && rd_addr == RA_TLO) && rd_en && rd_addr == RA_THI)
        |=> (rd_data == $past(time_ns[TIME_W-1:WORD_W], 2)));
endmodule

bind timebase_counter tbc_checker u_chk (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .time_ns(time_ns), .running(run_q),
    .drift_rst(drift_rst_q), .cfg(cfg_q)
);

// File: tb/timebase_counter_tb.sv
module timebase_counter_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] time_ns;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur = "R1";

    timebase_counter u_dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .time_ns(time_ns)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    logic [63:0] m_time;
    bit          m_run, m_drst;
    logic [31:0] m_cfg, m_rd, m_snap;
    int unsigned m_pc;

    always @(posedge clk) begin
        logic [63:0] o_time;
        bit          o_run, o_drst;
        logic [31:0] o_cfg, o_snap;
        int unsigned inc, per, mag;
        if (rst) begin
            m_time = 0; m_run = 1; m_drst = 0; m_cfg = 0; m_rd = 0; m_snap = 0; m_pc = 0;
        end else begin
            o_time = m_time; o_run = m_run; o_drst = m_drst; o_cfg = m_cfg; o_snap = m_snap;
            if (o_run) begin
                inc = 16;
                per = o_cfg & 32'h0FFF_FFFF;
                mag = (o_cfg >> 28) & 7;
                if (!o_drst && per != 0) begin
                    if (m_pc + 1 == per) begin
                        inc = o_cfg[31] ? 16 + mag : 16 - mag;
                        m_pc = 0;
                    end else m_pc++;
                end
                m_time = o_time + 64'(inc);
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: if (wr_data == 2) m_run = 0; else if (wr_data == 4) m_run = 1;
                    3'd1: if (!o_run) m_time[31:0] = wr_data;
                    3'd2: if (!o_run) m_time[63:32] = wr_data;
                    3'd3: begin m_drst = wr_data[0]; m_pc = 0; end
                    3'd4: if (o_drst) m_cfg = wr_data;
                    default: ;
                endcase
            end
            if (rd_en) begin
                case (rd_addr)
                    3'd0: begin m_rd = o_time[31:0]; m_snap = o_time[63:32]; end
                    3'd1: m_rd = o_snap;
                    3'd3: m_rd = {31'd0, o_drst};
                    3'd4: m_rd = o_cfg;
                    default: m_rd = 0;
                endcase
            end
        end
    end

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check64({cur, " time_ns"}, time_ns, m_time);
            check64({cur, " rd_data"}, {32'd0, rd_data}, {32'd0, m_rd});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d; rd_en = 0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(posedge clk); #1;
        wr_en = 0; rd_en = 1; rd_addr = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 0; rd_en = 0;
        end
    endtask

    function automatic logic [31:0] dcfg(bit add, int m, logic [27:0] p);
        return {add, 3'(m), p};
    endfunction

    initial begin
        logic [63:0] t0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check64("R1 reset time", time_ns, 64'd0);
        check64("R1 reset rd_data", {32'd0, rd_data}, 64'd0);

        cur = "R2"; idle(8);
        @(negedge clk); t0 = time_ns;
        idle(4); @(negedge clk);
        check64("R2 four ticks", time_ns, t0 + 64'd64);

        cur = "R3"; wr(0, 2); idle(1);
        @(negedge clk); t0 = time_ns;
        wr(0, 7); idle(3); @(negedge clk);
        check64("R3 paused hold", time_ns, t0);
        wr(0, 4); idle(3);

        cur = "R4"; wr(0, 2); wr(1, 32'hFFFF_FFC0); wr(2, 32'h0000_0001); idle(1);
        @(negedge clk);
        check64("R4 preload", time_ns, 64'h1_FFFF_FFC0);
        wr(0, 4); wr(1, 32'h5); idle(2);

        cur = "R10"; rd(0); rd(1); idle(2); rd(0); idle(3); rd(1); idle(1);
        rd(3); rd(4); rd(6); idle(1);

        cur = "R5"; wr(4, 32'h8000_0003); rd(4); idle(1); @(negedge clk);
        check64("R5 cfg ignored", {32'd0, rd_data}, 64'd0);

        cur = "R6"; wr(3, 1); wr(4, dcfg(1, 3, 28'd4)); rd(4); rd(3); wr(3, 0); idle(20);
        wr(3, 1); wr(4, dcfg(0, 7, 28'd1)); wr(3, 0); idle(6);
        wr(3, 1); wr(4, dcfg(1, 7, 28'd3)); wr(3, 0); idle(9);

        cur = "R9"; wr(3, 1); wr(4, dcfg(1, 5, 28'd5)); wr(3, 0); idle(2);
        wr(0, 2); idle(4); wr(0, 4); idle(8);

        cur = "R7"; wr(3, 1); wr(4, dcfg(0, 0, 28'hFFF_FFFF)); wr(3, 0); idle(1);
        @(negedge clk); t0 = time_ns;
        idle(5); @(negedge clk);
        check64("R7 magnitude zero", time_ns, t0 + 64'd80);
        wr(3, 1); wr(4, 0); wr(3, 0); idle(5);

        cur = "R8"; wr(3, 1); wr(4, dcfg(1, 7, 28'd1)); idle(1);
        @(negedge clk); t0 = time_ns;
        idle(6); @(negedge clk);
        check64("R8 held in drift reset", time_ns, t0 + 64'd96);
        wr(3, 0); idle(4);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule